// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a clocked cache memory with one shared data path and a two-bit burst address generator. Each word is 18 bits wide and is split into two 9-bit halves. Each half holds one byte and one parity bit and has its own write enable.

An access starts at a clock edge when chip select is low and one of two address strobes is low. The processor strobe only captures the address. Any write that follows it lands one edge later, so that outside tag logic has a cycle to approve it. The controller strobe writes at the edge that captures the address. After the start, an advance input steps through the remaining three words of the aligned group of four. The stepping order is interleaved or linear, selected by a parameter.

The bidirectional data pins appear as a data input, a data output and a per-half drive enable. The output enable acts without a clock. A half is never driven in the cycle after its write enable was sampled low. Memory depth is set by the address width parameter.

Top module: `burst_cache_ram`

## Requirements
- R1: An edge with chip select low, one strobe low and both write enables high starts a read. From that edge until the next one, data_o holds the addressed word, and both bits of data_oe_o are high while oe_ni is low.
- R2: An edge with chip select low and the processor strobe low writes nothing, even when write enables are low.
- R3: After a processor-strobe start, a later edge with the device selected, no strobe active and a write enable low writes data_i into the current burst address.
- R4: An edge with chip select low, controller strobe low, processor strobe high and a write enable low writes data_i into addr_i at that same edge.
- R5: When both strobes are low at one edge, the access is a processor-strobe start and nothing is written.
- R6: Bit 8 is parity 0 and bits 7..0 are data byte 0; we_lo_ni controls bits 8..0. Bit 17 is parity 1 and bits 16..9 are data byte 1; we_hi_ni controls bits 17..9. A half whose enable is high keeps its stored value.
- R7: A half whose write enable was low at the last edge is not driven until the next edge, whatever oe_ni is (data_oe_o bit 0 is the low half, bit 1 the high half).
- R8: While oe_ni is high, data_oe_o is 0, with no clock edge needed.
- R9: An edge with chip select high and controller strobe low deselects the device, and data_oe_o is 0 until the next start. With chip select high, the processor strobe is ignored.
- R10: A start loads the two low address bits as burst base b with step 0; advance is ignored at a start edge. Every other edge with adv_ni low increments the step k (mod 4). The word address is b XOR k when MODE is BURST_INTERLEAVED, and (b + k) mod 4 when MODE is BURST_LINEAR.
- R11: A non-start write on an edge with adv_ni low goes to the address after the advance. Without an advance, it goes to the current address.
- R12: After reset the device is deselected and data_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Burst advance, active low |
| we_hi_ni | input | 1 | High half write enable, active low |
| we_lo_ni | input | 1 | Low half write enable, active low |
| oe_ni | input | 1 | Output enable, active low, not clocked |
| data_i | input | 18 | Write data |
| data_o | output | 18 | Read data |
| data_oe_o | output | 2 | Per-half drive enable (bit 1 high half) |

## Verification
A wrong burst step or a wrong captured address shows on data_o one cycle after the edge that caused it. A wrong select or write-mask state shows on data_oe_o in that same cycle. A write that went to the wrong place, or that should have been suppressed, stays hidden until that location is read back. For that reason every write pattern is followed by reads of the affected words and of their neighbours. Both burst orders run side by side, so that an order fault appears as a divergence between two instances driven by the same stimulus.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int HALF_W   = 9;
  localparam int NUM_HALF = 2;
  localparam int WORD_W   = HALF_W * NUM_HALF;
  localparam int CNT_W    = 2;

  typedef enum logic {
    BURST_INTERLEAVED = 1'b0,
    BURST_LINEAR      = 1'b1
  } burst_mode_e;
endpackage

// File: rtl/bcr_burst_ctr.sv
module bcr_burst_ctr #(
  parameter int                  ADDR_W = 8,
  parameter bcr_pkg::burst_mode_e MODE  = bcr_pkg::BURST_INTERLEAVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  import bcr_pkg::*;
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] base_q, step_q, step_nxt;
  logic [CNT_W-1:0] cur_lsb, nxt_lsb;

  always_comb step_nxt = adv_i ? step_q + 1'b1 : step_q;

  generate
    if (MODE == BURST_LINEAR) begin : g_linear
      assign cur_lsb = base_q + step_q;
      assign nxt_lsb = base_q + step_nxt;
    end else begin : g_interleaved
      assign cur_lsb = base_q ^ step_q;
      assign nxt_lsb = base_q ^ step_nxt;
    end
  endgenerate

  assign cur_addr_o = {hi_q, cur_lsb};
  assign nxt_addr_o = {hi_q, nxt_lsb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      base_q <= '0;
      step_q <= '0;
    end else if (load_i) begin
      hi_q   <= addr_i[ADDR_W-1:CNT_W];
      base_q <= addr_i[CNT_W-1:0];
      step_q <= '0;
    end else begin
      step_q <= step_nxt;
    end
  end

  AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_addr_o == $past(addr_i)) else $error("load base");  // R10
  AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(cur_addr_o)) else $error("hold");  // R10
endmodule

// File: rtl/bcr_ctrl.sv
module bcr_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       proc_stb_ni,
  input  logic       ctrl_stb_ni,
  input  logic       adv_ni,
  input  logic [1:0] we_ni,
  output logic       load_o,
  output logic       adv_o,
  output logic       wr_new_o,
  output logic [1:0] wr_en_o,
  output logic [1:0] drive_o
);
  logic       proc_go, ctrl_go, desel;
  logic       sel_q;
  logic [1:0] wmask_q, we_act;

  assign proc_go = !cs_ni && !proc_stb_ni;
  assign ctrl_go = !cs_ni && proc_stb_ni && !ctrl_stb_ni;
  assign desel   = cs_ni && !ctrl_stb_ni;
  assign we_act  = ~we_ni;

  assign load_o   = proc_go || ctrl_go;
  assign adv_o    = !load_o && !adv_ni;
  assign wr_new_o = ctrl_go;

  // processor start never writes; continuation writes need a live selection
  always_comb begin
    if (ctrl_go)                        wr_en_o = we_act;
    else if (sel_q && !load_o && !desel) wr_en_o = we_act;
    else                                wr_en_o = 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      wmask_q <= 2'b00;
    end else begin
      wmask_q <= we_act;
      if (load_o)     sel_q <= 1'b1;
      else if (desel) sel_q <= 1'b0;
    end
  end

  assign drive_o = {2{sel_q}} & ~wmask_q;
endmodule

// File: rtl/bcr_array.sv
module bcr_array #(
  parameter int ADDR_W = 8
) (
  input  logic                       clk_i,
  input  logic [bcr_pkg::NUM_HALF-1:0] wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [bcr_pkg::WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [bcr_pkg::WORD_W-1:0] rd_data_o
);
  import bcr_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic [HALF_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i[h]) mem[wr_addr_i] <= wr_data_i[h*HALF_W +: HALF_W];
    end
    assign rd_data_o[h*HALF_W +: HALF_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/burst_cache_ram.sv
module burst_cache_ram #(
  parameter int                  ADDR_W = 8,
  parameter bcr_pkg::burst_mode_e MODE  = bcr_pkg::BURST_INTERLEAVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_ni,
  input  logic              ctrl_stb_ni,
  input  logic              cs_ni,
  input  logic              adv_ni,
  input  logic              we_hi_ni,
  input  logic              we_lo_ni,
  input  logic              oe_ni,
  input  logic [17:0]       data_i,
  output logic [17:0]       data_o,
  output logic [1:0]        data_oe_o
);
  logic              load, adv, wr_new;
  logic [1:0]        wr_en, drive;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, wr_addr;

  bcr_ctrl i_ctrl (
    .clk_i, .rst_ni, .cs_ni, .proc_stb_ni, .ctrl_stb_ni, .adv_ni,
    .we_ni   ({we_hi_ni, we_lo_ni}),
    .load_o  (load),
    .adv_o   (adv),
    .wr_new_o(wr_new),
    .wr_en_o (wr_en),
    .drive_o (drive)
  );

  bcr_burst_ctr #(.ADDR_W(ADDR_W), .MODE(MODE)) i_ctr (
    .clk_i, .rst_ni,
    .load_i    (load),
    .adv_i     (adv),
    .addr_i    (addr_i),
    .cur_addr_o(cur_addr),
    .nxt_addr_o(nxt_addr)
  );

  assign wr_addr = wr_new ? addr_i : nxt_addr;

  bcr_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i,
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(data_i),
    .rd_addr_i(cur_addr),
    .rd_data_o(data_o)
  );

  assign data_oe_o = {2{!oe_ni}} & drive;

  AST_PROC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !proc_stb_ni) |-> wr_en == 2'b00) else $error("proc wr");  // R2
  AST_BOTH_STB_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !proc_stb_ni && !ctrl_stb_ni) |-> !wr_en[1]) else $error("both");  // R5
  AST_CTRL_WRITE_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && proc_stb_ni && !ctrl_stb_ni && !we_lo_ni) |-> wr_en[0] && wr_addr == addr_i)
    else $error("ctrl wr");  // R4
  AST_WE_LO_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_lo_ni |=> !data_oe_o[0]) else $error("lo tri");  // R7
  AST_WE_HI_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_hi_ni |=> !data_oe_o[1]) else $error("hi tri");  // R7
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> data_oe_o == 2'b00) else $error("oe");  // R8
  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !ctrl_stb_ni) |=> data_oe_o == 2'b00) else $error("desel");  // R9
endmodule

// File: tb/test_burst_cache_ram.sv
module test_burst_cache_ram;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic ps_n = 1, cc_n = 1, cs_n = 1, adv_n = 1, wh_n = 1, wl_n = 1, oe_n = 0;
  logic [17:0] din = '0;
  logic [17:0] dout [2];
  logic [1:0]  doe [2];

  burst_cache_ram #(.ADDR_W(AW), .MODE(bcr_pkg::BURST_INTERLEAVED)) i_burst_cache_ram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(ps_n), .ctrl_stb_ni(cc_n),
    .cs_ni(cs_n), .adv_ni(adv_n), .we_hi_ni(wh_n), .we_lo_ni(wl_n), .oe_ni(oe_n),
    .data_i(din), .data_o(dout[0]), .data_oe_o(doe[0]));

  burst_cache_ram #(.ADDR_W(AW), .MODE(bcr_pkg::BURST_LINEAR)) i_burst_cache_ram_lin (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(ps_n), .ctrl_stb_ni(cc_n),
    .cs_ni(cs_n), .adv_ni(adv_n), .we_hi_ni(wh_n), .we_lo_ni(wl_n), .oe_ni(oe_n),
    .data_i(din), .data_o(dout[1]), .data_oe_o(doe[1]));

  int checks = 0, errors = 0;

  typedef struct {
    logic [17:0] d [2];
    logic [1:0]  oe [2];
    logic [1:0]  vld [2];
    string       tag;
  } exp_t;
  exp_t q[$];

  // behavioural model, one per burst order
  logic [17:0] m_mem [2][1 << AW];
  logic [1:0]  m_vld [2][1 << AW];
  logic [AW-3:0] m_hi [2];
  logic [1:0]  m_base [2], m_step [2], m_wmask [2];
  logic        m_sel [2];

  function automatic logic [1:0] lsb(int m, logic [1:0] b, logic [1:0] s);
    return (m == 1) ? b + s : b ^ s;
  endfunction

  task automatic m_write(int m, logic [AW-1:0] a, logic [1:0] we, logic [17:0] d);
    for (int h = 0; h < 2; h++) if (we[h]) begin
      m_mem[m][a][h*9 +: 9] = d[h*9 +: 9];
      m_vld[m][a][h] = 1'b1;
    end
  endtask

  task automatic drv(logic cs, logic ps, logic cc, logic av, logic wh, logic wl, logic oe,
                     logic [AW-1:0] a, logic [17:0] d, string tag);
    exp_t e;
    @(negedge clk); #2;
    cs_n = cs; ps_n = ps; cc_n = cc; adv_n = av; wh_n = wh; wl_n = wl; oe_n = oe;
    addr = a; din = d;
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++) begin
      logic pg, cg, ld, ds;
      logic [1:0] we, ns;
      pg = !cs && !ps; cg = !cs && ps && !cc; ld = pg || cg; ds = cs && !cc;
      we = {!wh, !wl};
      ns = !av ? m_step[m] + 2'd1 : m_step[m];
      if (cg) m_write(m, a, we, d);
      else if (!ld && !ds && m_sel[m]) m_write(m, {m_hi[m], lsb(m, m_base[m], ns)}, we, d);
      if (ld) begin
        m_hi[m] = a[AW-1:2]; m_base[m] = a[1:0]; m_step[m] = 2'd0;
      end else m_step[m] = ns;
      if (ld) m_sel[m] = 1'b1;
      else if (ds) m_sel[m] = 1'b0;
      m_wmask[m] = we;
      begin
        logic [AW-1:0] ra;
        ra = {m_hi[m], lsb(m, m_base[m], m_step[m])};
        e.d[m] = m_mem[m][ra];
        e.vld[m] = m_vld[m][ra];
        e.oe[m] = {2{!oe && m_sel[m]}} & ~m_wmask[m];
      end
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        for (int m = 0; m < 2; m++) begin
          logic bad;
          bad = (doe[m] !== e.oe[m]);
          for (int h = 0; h < 2; h++)
            if (e.oe[m][h] && e.vld[m][h] && dout[m][h*9 +: 9] !== e.d[m][h*9 +: 9]) bad = 1'b1;
          checks++;
          if (bad) begin
            errors++;
            $display("FAIL %s inst%0d: data=%h oe=%b expected data=%h oe=%b",
                     e.tag, m, dout[m], doe[m], e.d[m], e.oe[m]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // shorthands
  task automatic ctrl_wr(logic [AW-1:0] a, logic [17:0] d, logic wh, logic wl, string t);
    drv(0, 1, 0, 1, wh, wl, 0, a, d, t);
  endtask
  task automatic ctrl_rd(logic [AW-1:0] a, string t);
    drv(0, 1, 0, 1, 1, 1, 0, a, '0, t);
  endtask
  task automatic cont(logic av, logic wh, logic wl, logic [17:0] d, string t);
    drv(1, 1, 1, av, wh, wl, 0, '0, d, t);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_sel[m] = 0; m_wmask[m] = 0; m_hi[m] = 0; m_base[m] = 0; m_step[m] = 0;
      for (int i = 0; i < (1 << AW); i++) m_vld[m][i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #4;
    for (int m = 0; m < 2; m++) begin
      checks++;
      if (doe[m] !== 2'b00) begin
        errors++;
        $display("FAIL R12 inst%0d: data_oe=%b expected 00", m, doe[m]);
      end
    end

    for (int i = 0; i < 4; i++) ctrl_wr(8'h10 + i, 18'h10a00 + 18'(i * 18'h00b1), 0, 0, "R4");
    ctrl_rd(8'h10, "R1");
    cont(1, 1, 1, '0, "R1");
    // burst from base 1: orders differ between instances
    ctrl_rd(8'h11, "R10");
    cont(0, 1, 1, '0, "R10");
    cont(0, 1, 1, '0, "R10");
    cont(1, 1, 1, '0, "R10");
    cont(0, 1, 1, '0, "R10");
    cont(0, 1, 1, '0, "R10");
    drv(0, 0, 1, 0, 1, 1, 0, 8'h13, '0, "R10");  // advance ignored on start
    cont(0, 1, 1, '0, "R10");

    ctrl_wr(8'h21, 18'h2aaaa, 0, 0, "R4");
    ctrl_wr(8'h22, 18'h15555, 0, 0, "R4");
    drv(0, 0, 1, 1, 0, 0, 0, 8'h21, 18'h3ffff, "R2");
    cont(1, 1, 1, '0, "R2");
    drv(0, 0, 1, 1, 1, 1, 0, 8'h20, '0, "R3");
    cont(1, 0, 0, 18'h0c3c3, "R3");
    ctrl_rd(8'h20, "R3");
    drv(0, 0, 0, 1, 0, 0, 0, 8'h22, 18'h00001, "R5");
    cont(1, 1, 1, '0, "R5");

    ctrl_wr(8'h10, 18'h1ff00, 1, 0, "R7");
    ctrl_rd(8'h10, "R6");
    ctrl_wr(8'h11, 18'h0abcd, 0, 1, "R7");
    ctrl_rd(8'h11, "R6");

    drv(0, 0, 1, 1, 1, 1, 0, 8'h31, '0, "R11");
    cont(0, 0, 0, 18'h31313, "R11");
    cont(1, 1, 0, 18'h00077, "R11");
    for (int i = 0; i < 4; i++) ctrl_rd(8'h30 + i, "R11");

    drv(0, 1, 0, 1, 1, 1, 1, 8'h20, '0, "R8");
    cont(1, 1, 1, '0, "R8");
    drv(1, 1, 0, 1, 1, 1, 0, 8'h10, '0, "R9");
    drv(1, 0, 1, 1, 1, 1, 0, 8'h11, '0, "R9");
    cont(1, 1, 1, '0, "R9");
    ctrl_rd(8'h12, "R1");
    repeat (3) cont(1, 1, 1, '0, "R1");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule